// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a virtual address into a physical address. It walks a three-level hierarchical page table that sits in main memory. A translation request arrives on a valid/ready port. The walker takes the top-level table frame from a plain input pin at the moment it accepts the request. It then issues one memory read for each level, in strict order. Each read after the first gets its table base from the entry that was just returned. Once the last-level entry arrives, the walker joins that entry's frame number with the untouched page offset and presents the result on a valid/ready response port. If a walk meets an entry whose present bit is clear, it stops at once and reports a fault that names the level.

Tables are one page each: an 8 KB page of 4-byte entries, which gives 2048 entries per table. A 46-bit virtual address therefore carries three 11-bit indices above a 13-bit page offset. Physical addresses are 33 bits wide, so frame numbers are 20 bits. Every entry address is formed as (table frame × 8192) + (index × 4).

Back-pressure rules:
- On the request side, a request is taken only on a cycle where `req_valid` and `req_ready` are both high.
- On the response side, the response and all its fields stay unchanged until `rsp_ready` is seen high.
- On the memory side, the read request stays unchanged until `mem_req_ready` is seen high. The response arrives as a single-cycle `mem_rsp_valid` pulse, which the walker always accepts.

Top module: `ptw_walker3`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: The level indices are fixed fields of the virtual address: top level bits [45:35], middle level bits [34:24], last level bits [23:13]. The page offset is bits [12:0].
- R3: The first read address is `root_pfn`×8192 + (top index)×4. `root_pfn` is sampled on the acceptance cycle, and later changes to it do not affect a walk in progress.
- R4: Each later read address is F×8192 + index×4, where F is bits [31:12] of the entry returned by the previous read.
- R5: At most one read is outstanding. After a memory request handshake, `mem_req_valid` stays low until the matching `mem_rsp_valid` has been taken.
- R6: Bit 0 of an entry is its present bit. A clear present bit at any level ends the walk with `rsp_fault`=1 and `rsp_fault_lvl` set to 0, 1 or 2 for the top, middle and last level. No further read is issued, and `rsp_pa` is 0.
- R7: On success, `rsp_pa` = {last-level entry bits [31:12], VA bits [12:0]} and `rsp_fault`=0. Entry bits [11:1], which hold the protection and dirty attributes, have no effect on the result.
- R8: `req_ready` is high only when the walker is idle. No new request is accepted between an acceptance and the handshake of its response.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response and its fields hold steady.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted with a stable address.
- R11: A successful translation issues exactly three reads. A fault at level L issues exactly L+1 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_pfn | input | 20 | Frame number of the top-level table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 46 | Virtual address to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_pa | output | 33 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Walk stopped on a non-present entry |
| rsp_fault_lvl | output | 2 | Level of the failing entry (0 = top) |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 33 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Single-cycle pulse carrying the read data |
| mem_rsp_data | input | 32 | Entry returned by memory |

## Verification
The assertions rely on three assumptions about the memory side:
- `mem_rsp_valid` pulses exactly once for each accepted read.
- That pulse comes only after the read handshake.
- The pulse lasts one cycle.

The bench's memory responder keeps to these rules. It latches each accepted read, waits a chosen latency of zero to four cycles, and drives one pulse with the stored entry. It never answers when no read is pending.

The request side carries no assumption beyond valid/ready. The bench deliberately holds `req_valid` high while a walk is in progress, and it switches `root_pfn` mid-walk, to show that both are ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PTW_LEVELS = 3;
  localparam int PTW_IDX_W  = 11;
  localparam int PTW_OFF_W  = 13;
  localparam int PTW_PA_W   = 33;
  localparam int PTW_PTE_W  = 32;
  localparam int PTW_ENT_SH = 2;

  typedef enum logic [1:0] {
    WK_IDLE,
    WK_ISSUE,
    WK_WAIT,
    WK_RESP
  } wk_state_e;
endpackage

// File: rtl/ptw_idx_sel.sv
module ptw_idx_sel #(
  parameter int LEVELS = 3,
  parameter int IDX_W  = 11,
  parameter int OFF_W  = 13,
  parameter int LVL_W  = 2
) (
  input  logic [OFF_W+LEVELS*IDX_W-1:0] va,
  input  logic [LVL_W-1:0]              lvl,
  output logic [IDX_W-1:0]              idx
);
  logic [IDX_W-1:0] fld [LEVELS];

  // Top level uses the most significant index field.
  for (genvar g = 0; g < LEVELS; g++) begin : g_fld
    assign fld[g] = va[OFF_W + (LEVELS-1-g)*IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (lvl == LVL_W'(k)) idx = fld[k];
    end
  end
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int PA_W   = 33,
  parameter int OFF_W  = 13,
  parameter int IDX_W  = 11,
  parameter int ENT_SH = 2
) (
  input  logic [PA_W-OFF_W-1:0] base_pfn,
  input  logic [IDX_W-1:0]      idx,
  output logic [PA_W-1:0]       addr
);
  localparam int SCALED_W = IDX_W + ENT_SH;

  logic [SCALED_W-1:0] scaled;
  assign scaled = {idx, {ENT_SH{1'b0}}};
  assign addr   = {base_pfn, {OFF_W{1'b0}}} + PA_W'(scaled);
endmodule

// File: rtl/ptw_pte_fields.sv
module ptw_pte_fields #(
  parameter int PTE_W = 32,
  parameter int PFN_W = 20
) (
  input  logic [PTE_W-1:0] pte,
  output logic             present,
  output logic [PFN_W-1:0] pfn
);
  logic unused_attr;

  assign present     = pte[0];
  assign pfn         = pte[PTE_W-1 -: PFN_W];
  assign unused_attr = ^pte[PTE_W-PFN_W-1:1];
endmodule

// File: rtl/ptw_walker3.sv
module ptw_walker3
  import ptw_pkg::*;
#(
  parameter int LEVELS = PTW_LEVELS,
  parameter int IDX_W  = PTW_IDX_W,
  parameter int OFF_W  = PTW_OFF_W,
  parameter int PA_W   = PTW_PA_W,
  parameter int PTE_W  = PTW_PTE_W,
  parameter int ENT_SH = PTW_ENT_SH
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [PA_W-OFF_W-1:0]         root_pfn,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [OFF_W+LEVELS*IDX_W-1:0] req_va,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [PA_W-1:0]               rsp_pa,
  output logic                          rsp_fault,
  output logic [$clog2(LEVELS)-1:0]     rsp_fault_lvl,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic [PA_W-1:0]               mem_req_addr,
  input  logic                          mem_rsp_valid,
  input  logic [PTE_W-1:0]              mem_rsp_data
);
  localparam int VA_W  = OFF_W + LEVELS*IDX_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int LVL_W = $clog2(LEVELS);
  localparam int CNT_W = LVL_W + 1;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS-1);

  wk_state_e        st_q;
  logic [LVL_W-1:0] lvl_q;
  logic [VA_W-1:0]  va_q;
  logic [PFN_W-1:0] base_q;
  logic [PA_W-1:0]  pa_q;
  logic             flt_q;
  logic [LVL_W-1:0] flvl_q;

  logic [IDX_W-1:0] cur_idx;
  logic             pte_present;
  logic [PFN_W-1:0] pte_pfn;

  ptw_idx_sel #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .LVL_W(LVL_W)
  ) u_idx (
    .va(va_q), .lvl(lvl_q), .idx(cur_idx)
  );

  ptw_entry_addr #(
    .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_SH(ENT_SH)
  ) u_addr (
    .base_pfn(base_q), .idx(cur_idx), .addr(mem_req_addr)
  );

  ptw_pte_fields #(
    .PTE_W(PTE_W), .PFN_W(PFN_W)
  ) u_pte (
    .pte(mem_rsp_data), .present(pte_present), .pfn(pte_pfn)
  );

  assign req_ready     = (st_q == WK_IDLE);
  assign mem_req_valid = (st_q == WK_ISSUE);
  assign rsp_valid     = (st_q == WK_RESP);
  assign rsp_pa        = pa_q;
  assign rsp_fault     = flt_q;
  assign rsp_fault_lvl = flvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= WK_IDLE;
      lvl_q  <= '0;
      va_q   <= '0;
      base_q <= '0;
      pa_q   <= '0;
      flt_q  <= 1'b0;
      flvl_q <= '0;
    end else begin
      case (st_q)
        WK_IDLE: begin
          if (req_valid) begin
            va_q   <= req_va;
            base_q <= root_pfn;
            lvl_q  <= '0;
            pa_q   <= '0;
            flt_q  <= 1'b0;
            flvl_q <= '0;
            st_q   <= WK_ISSUE;
          end
        end
        WK_ISSUE: begin
          if (mem_req_ready) st_q <= WK_WAIT;
        end
        WK_WAIT: begin
          if (mem_rsp_valid) begin
            if (!pte_present) begin
              flt_q  <= 1'b1;
              flvl_q <= lvl_q;
              st_q   <= WK_RESP;
            end else if (lvl_q == LAST_LVL) begin
              pa_q <= {pte_pfn, va_q[OFF_W-1:0]};
              st_q <= WK_RESP;
            end else begin
              base_q <= pte_pfn;
              lvl_q  <= lvl_q + 1'b1;
              st_q   <= WK_ISSUE;
            end
          end
        end
        WK_RESP: begin
          if (rsp_ready) st_q <= WK_IDLE;
        end
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  // Read counter kept only for the checks below.
  logic [CNT_W-1:0] rd_cnt_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt_q <= '0;
    end else if (req_valid && req_ready) begin
      rd_cnt_q <= '0;
    end else if (mem_req_valid && mem_req_ready) begin
      rd_cnt_q <= rd_cnt_q + 1'b1;
    end
  end

  a_r5_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault) && $stable(rsp_fault_lvl)));

  a_r11_three_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rd_cnt_q == CNT_W'(LEVELS)));

  a_r6_fault_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rd_cnt_q == CNT_W'(rsp_fault_lvl) + 1'b1));

  a_r6_fault_pa_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_pa == '0));

  a_r8_hold_va: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready) |=> $stable(va_q));
endmodule

// File: tb/ptw_walker3_tb_top.sv
`timescale 1ns/1ps
module ptw_walker3_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] root_pfn;
  logic        req_valid;
  logic        req_ready;
  logic [45:0] req_va;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [32:0] rsp_pa;
  logic        rsp_fault;
  logic [1:0]  rsp_fault_lvl;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [32:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  always #2 clk = ~clk;

  ptw_walker3 dut_i (
    .clk(clk), .rst_n(rst_n), .root_pfn(root_pfn),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
    .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  bit [31:0]        mem_m [longint unsigned];
  longint unsigned  exp_addr [$];
  int               checks = 0, fails = 0, cyc = 0;
  int               acc_cnt = 0, rsp_cnt = 0, rd_no = 0;
  int               mem_mode = 0, rsp_mode = 0, max_lat = 0, lat = 0;
  bit               busy_m = 0, pend = 0, finished = 0, run_model = 0;
  longint unsigned  pend_addr;
  bit               exp_fault;
  int               exp_lvl;
  logic [32:0]      exp_pa;

  function automatic longint unsigned eaddr(logic [19:0] b, logic [10:0] i);
    return (64'(b) << 13) + (64'(i) << 2);
  endfunction

  function automatic logic [10:0] fld(logic [45:0] va, int l);
    return va[45-11*l -: 11];
  endfunction

  function automatic bit [31:0] rd(longint unsigned a);
    return mem_m.exists(a) ? mem_m[a] : 32'h0;
  endfunction

  function automatic logic [45:0] mkva(logic [10:0] a, logic [10:0] b, logic [10:0] c, logic [12:0] o);
    return {a, b, c, o};
  endfunction

  function automatic bit pick(int mode);
    if (mode == 0) return 1'b1;
    if (mode == 1) return cyc[0];
    return 1'($urandom_range(0, 1));
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic map3(logic [19:0] root, logic [45:0] va, logic [19:0] p2,
                      logic [19:0] p3, logic [19:0] frame, logic [3:0] attr);
    mem_m[eaddr(root, fld(va, 0))] = {p2, 7'h0, attr, 1'b1};
    mem_m[eaddr(p2, fld(va, 1))]   = {p3, 7'h0, attr, 1'b1};
    mem_m[eaddr(p3, fld(va, 2))]   = {frame, 7'h0, attr, 1'b1};
  endtask

  // Reference walk computed from the requirements at acceptance.
  task automatic model_walk(logic [45:0] va, logic [19:0] root);
    logic [19:0] base;
    bit [31:0]   d;
    longint unsigned a;
    base = root;
    exp_fault = 0; exp_lvl = 0; exp_pa = '0; rd_no = 0;
    exp_addr.delete();
    for (int l = 0; l < 3; l++) begin
      a = eaddr(base, fld(va, l));
      exp_addr.push_back(a);
      d = rd(a);
      if (!d[0]) begin
        exp_fault = 1; exp_lvl = l;
        break;
      end
      base = d[31:12];
      if (l == 2) exp_pa = {d[31:12], va[12:0]};
    end
  endtask

  // Per-clock reference and memory responder, acting between edges.
  always @(negedge clk) begin
    if (rst_n && run_model && !finished) begin
      #1;
      chk(!(busy_m && req_ready), "R8 ready while busy", req_ready, 0);
      chk(!(pend && mem_req_valid), "R5 read while outstanding", mem_req_valid, 0);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(pend_addr);
          pend = 0;
        end else begin
          lat--;
        end
      end
      mem_req_ready = pick(mem_mode);
      if (mem_req_valid && mem_req_ready) begin
        if (exp_addr.size() == 0) begin
          chk(0, "R11 extra read", mem_req_addr, 0);
        end else begin
          chk(mem_req_addr == exp_addr[0], rd_no == 0 ? "R2 R3 first address" : "R2 R4 next address",
              mem_req_addr, exp_addr[0]);
          void'(exp_addr.pop_front());
        end
        rd_no++;
        pend = 1; pend_addr = mem_req_addr;
        lat = $urandom_range(0, max_lat);
      end
      rsp_ready = pick(rsp_mode);
      if (rsp_valid && rsp_ready) begin
        chk(exp_addr.size() == 0, "R11 R6 read count", exp_addr.size(), 0);
        chk(rsp_fault == exp_fault, "R6 fault flag", rsp_fault, exp_fault);
        if (exp_fault) begin
          chk(rsp_fault_lvl == exp_lvl[1:0], "R6 fault level", rsp_fault_lvl, exp_lvl);
          chk(rsp_pa == '0, "R6 pa zero", rsp_pa, 0);
        end else begin
          chk(rsp_pa == exp_pa, "R7 physical address", rsp_pa, exp_pa);
        end
        busy_m = 0;
        rsp_cnt++;
      end
      if (req_valid && req_ready && !busy_m) begin
        model_walk(req_va, root_pfn);
        busy_m = 1;
        acc_cnt++;
      end
    end
  end

  task automatic run(logic [45:0] va, logic [19:0] root, bit flip);
    int a0;
    a0 = acc_cnt;
    @(negedge clk);
    root_pfn = root; req_va = va; req_valid = 1'b1;
    do @(negedge clk); while (acc_cnt == a0);
    req_valid = 1'b0;
    if (flip) root_pfn = 20'd40;
    while (rsp_cnt < acc_cnt) @(negedge clk);
  endtask

  task automatic run_b2b(logic [45:0] va1, logic [45:0] va2, logic [19:0] root);
    int a0;
    a0 = acc_cnt;
    @(negedge clk);
    root_pfn = root; req_va = va1; req_valid = 1'b1;
    do @(negedge clk); while (acc_cnt == a0);
    req_va = va2;
    do @(negedge clk); while (acc_cnt < a0 + 2);
    req_valid = 1'b0;
    while (rsp_cnt < acc_cnt) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !finished) begin
        fails++;
        $display("FAIL watchdog act=%0d exp=done", cyc);
        finish_up();
      end
    end
  end

  logic [45:0] va1, va2, va3, va4, va5, va6, va7, va8;

  initial begin
    rst_n = 1'b0; root_pfn = '0; req_valid = 1'b0; req_va = '0;
    rsp_ready = 1'b0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;

    va1 = mkva(11'd3, 11'd7, 11'd9, 13'h1ABC);
    va2 = mkva(11'd2047, 11'd2047, 11'd2047, 13'h1FFF);
    va3 = mkva(11'd0, 11'd0, 11'd0, 13'h0);
    va4 = mkva(11'd3, 11'd8, 11'd1, 13'h0042);
    va5 = mkva(11'd100, 11'd0, 11'd0, 13'h5);
    va6 = mkva(11'd3, 11'd500, 11'd0, 13'h5);
    va7 = mkva(11'd3, 11'd7, 11'd600, 13'h5);
    va8 = mkva(11'd4, 11'd1, 11'd1, 13'h1);
    map3(20'd5, va1, 20'd9, 20'd10, 20'hABCDE, 4'hF);
    map3(20'd5, va2, 20'd11, 20'd12, 20'hFFFFF, 4'hA);
    map3(20'd5, va3, 20'd13, 20'd14, 20'h00001, 4'h0);
    map3(20'd5, va4, 20'd9, 20'd15, 20'h12345, 4'h5);
    mem_m[eaddr(20'd5, 11'd4)] = {20'h0001E, 7'h7F, 4'hF, 1'b0};
    mem_m[eaddr(20'h0001E, 11'd1)] = {20'h00020, 7'h0, 4'h0, 1'b1};
    map3(20'd40, va1, 20'd41, 20'd42, 20'h77777, 4'h3);

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", mem_req_valid, 0);
    run_model = 1;

    for (int ph = 0; ph < 3; ph++) begin
      mem_mode = ph; rsp_mode = ph; max_lat = ph * 2;
      run(va1, 20'd5, 0);   // R7 R11 success path
      run(va2, 20'd5, 0);   // R2 all-ones indices and offset
      run(va3, 20'd5, 0);   // R2 all-zero indices
      run(va4, 20'd5, 0);   // R4 shared middle table
      run(va5, 20'd5, 0);   // R6 top-level fault
      run(va6, 20'd5, 0);   // R6 middle-level fault
      run(va7, 20'd5, 0);   // R6 last-level fault
      run(va8, 20'd5, 0);   // R6 present clear with nonzero frame
      run(va1, 20'd40, 0);  // R3 other root
    end
    mem_mode = 2; rsp_mode = 2; max_lat = 4;
    run(va1, 20'd5, 1);     // R3 root change mid-walk ignored
    run_b2b(va2, va4, 20'd5); // R8 held request waits for response
    mem_mode = 1; rsp_mode = 1; max_lat = 3;
    run_b2b(va7, va3, 20'd5); // R9 R10 back-pressure on both sides

    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R8 idle at end", req_ready, 1);
    finish_up();
  end
endmodule